// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked request port and an external static RAM that has no clock of its own. A user posts one access at a time (address, write data, a per-byte lane mask and a direction flag) while `busy` is low. The controller then plays out the strobe sequence the RAM needs: chip selects of opposite polarity, a write-enable pulse, an output-enable window and active-low lane enables. It also switches the bidirectional data bus between driving and listening. It finishes by raising `done` for one cycle. For reads, the captured word is presented on `rd_data` in that cycle.

Every analog limit of the RAM is given as a time in picoseconds. These cover write-enable width, data setup, write cycle, address-to-data and output-enable-to-data. The package turns each one into a whole number of clock cycles, with a floor of one. A start-up counter keeps the controller busy after reset until the supply-settling delay has passed. Because no access can start before then, the RAM stays deselected. The data bus is split into a driven half, a sensed half and a drive enable, so that the pad tristate lives outside the block.

Top module: `sramc_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the RAM is deselected (`mem_sel_n`=1, `mem_sel`=0), `mem_wr_n`, `mem_rd_n` and both `mem_lane_n` bits are 1, `mem_dq_drive` is 0 and `done` is 0.
- R2: After reset is released, `busy` stays 1 for exactly ceil(T_POWERUP_PS/CLK_PS) clock edges and the RAM stays deselected. A request presented during that window is dropped and never reaches the RAM.
- R3: A write keeps the RAM selected for its whole length. First come SETUP cycles with `mem_wr_n`=1, where SETUP = max(1, ceil(T_SA_PS/CLK_PS)). Next, `mem_wr_n` is 0 for PULSE cycles, where PULSE = max(1, ceil(max(T_PWE_PS,T_SD_PS)/CLK_PS)). Last come HOLD cycles with `mem_wr_n`=1, where HOLD = max(1, ceil(T_WC_PS/CLK_PS) - SETUP - PULSE). `mem_dq_drive` is 1 across these phases and at no other time.
- R4: Mask bit 0 enables the low lane (data bits 7:0, `mem_lane_n[0]` driven 0). Mask bit 1 enables the high lane (bits 15:8, `mem_lane_n[1]` driven 0). A write leaves disabled lanes of the addressed word unchanged, and a write with mask 00 changes nothing.
- R5: A read selects the RAM for one cycle with `mem_rd_n`=1. It then holds `mem_rd_n`=0 for ACCESS = max(1, ceil(max(T_AA_PS,T_DOE_PS)/CLK_PS)) cycles and samples `mem_dq_i` at the clock edge that ends the last of those cycles.
- R6: `done` is a single-cycle pulse in the cycle after an access's last phase. For a read, `rd_data` holds the sampled word from that cycle until the next read completes.
- R7: Lanes that a read's mask does not enable are returned as zero in `rd_data`, whatever the RAM drives on them.
- R8: `busy` is 1 from the edge that accepts a request until the `done` cycle. A request presented while `busy` is 1 is ignored.
- R9: `mem_dq_drive` and an active `mem_rd_n` never coincide, and `mem_rd_n` only falls after a cycle in which the bus was not driven. A read issued in the `done` cycle of a write sees exactly two undriven cycles before `mem_rd_n` falls.
- R10: While the RAM stays selected from one cycle to the next, `mem_addr` and `mem_lane_n` do not change.
- R11: The two chip selects always carry opposite levels (`mem_sel_n` equals the inverse of `mem_sel`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is 0 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_bmask | input | DATA_W/8 | Lane mask, bit 0 = bits 7:0 |
| busy | output | 1 | Start-up wait or access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Last read word, disabled lanes zero |
| mem_addr | output | ADDR_W | RAM address |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_rd_n | output | 1 | Active-low output enable |
| mem_lane_n | output | DATA_W/8 | Active-low lane enables, bit 0 = low byte |
| mem_dq_o | output | DATA_W | Data driven toward the RAM |
| mem_dq_drive | output | 1 | Pad driver enable for `mem_dq_o` |
| mem_dq_i | input | DATA_W | Data sensed from the RAM |

## Verification
The bound checker watches several rules on every cycle: the chip-select pair stays complementary, the write strobe only appears while the bus is driven and the RAM selected, the bus is never driven against an open output enable, and address and lane enables hold still while selected. It also confirms the idle state after reset, the start-up lockout and that `done` lasts one cycle. Only the scenarios can show the exact pulse and access lengths, because the bench RAM model returns garbage when sampled too early. The same holds for byte merging in memory, zeroing of disabled read lanes, requests dropped during start-up or while busy, and the precise turnaround count between a write and a following read.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

    // access phases, shared by sequencer and strobe decoder
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WSETUP,
        PH_WPULSE,
        PH_WHOLD,
        PH_RTURN,
        PH_RACCESS
    } phase_e;

    // internal strobes, all active high
    typedef struct packed {
        logic sel;
        logic wr;
        logic rd;
        logic lanes_on;
        logic drive;
    } strobe_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // whole cycles covering a time, never below one
    function automatic int cycles_for(input int t_ps, input int clk_ps);
        int c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return max2(c, 1);
    endfunction

endpackage

// File: rtl/sramc_powerup.sv
module sramc_powerup #(
    parameter int CYCLES = 100000
) (
    input  logic clk,
    input  logic rst,
    output logic pwr_ok
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            pwr_ok <= 1'b0;
        end else if (!pwr_ok) begin
            if (cnt_q == CW'(CYCLES - 1)) begin
                pwr_ok <= 1'b1;
            end
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sramc_seq.sv
module sramc_seq
    import sramc_pkg::*;
#(
    parameter int SETUP  = 1,
    parameter int PULSE  = 1,
    parameter int HOLD   = 1,
    parameter int ACCESS = 1
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   start_write,
    output phase_e phase_q,
    output phase_e phase_nx,
    output logic   capture,
    output logic   done
);
    localparam int LONGEST = max2(max2(SETUP, PULSE), max2(HOLD, ACCESS));
    localparam int CW      = $clog2(LONGEST + 1) + 1;

    logic [CW-1:0] cnt_q, cnt_nx;
    logic          last;
    logic          finish_nx;

    assign last    = (cnt_q == '0);
    assign capture = (phase_q == PH_RACCESS) && last;

    always_comb begin
        phase_nx  = phase_q;
        cnt_nx    = cnt_q - 1'b1;
        finish_nx = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                cnt_nx = '0;
                if (start) begin
                    if (start_write) begin
                        phase_nx = PH_WSETUP;
                        cnt_nx   = CW'(SETUP - 1);
                    end else begin
                        phase_nx = PH_RTURN;
                    end
                end
            end
            PH_WSETUP: if (last) begin
                phase_nx = PH_WPULSE;
                cnt_nx   = CW'(PULSE - 1);
            end
            PH_WPULSE: if (last) begin
                phase_nx = PH_WHOLD;
                cnt_nx   = CW'(HOLD - 1);
            end
            PH_WHOLD: if (last) begin
                phase_nx  = PH_IDLE;
                cnt_nx    = '0;
                finish_nx = 1'b1;
            end
            PH_RTURN: begin
                phase_nx = PH_RACCESS;
                cnt_nx   = CW'(ACCESS - 1);
            end
            PH_RACCESS: if (last) begin
                phase_nx  = PH_IDLE;
                cnt_nx    = '0;
                finish_nx = 1'b1;
            end
            default: begin
                phase_nx = PH_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            done    <= 1'b0;
        end else begin
            phase_q <= phase_nx;
            cnt_q   <= cnt_nx;
            done    <= finish_nx;
        end
    end
endmodule

// File: rtl/sramc_decode.sv
module sramc_decode
    import sramc_pkg::*;
(
    input  phase_e  phase,
    output strobe_t strb
);
    always_comb begin
        strb = '0;
        unique case (phase)
            PH_WSETUP, PH_WHOLD: begin
                strb.sel      = 1'b1;
                strb.lanes_on = 1'b1;
                strb.drive    = 1'b1;
            end
            PH_WPULSE: begin
                strb.sel      = 1'b1;
                strb.lanes_on = 1'b1;
                strb.drive    = 1'b1;
                strb.wr       = 1'b1;
            end
            PH_RTURN: begin
                strb.sel      = 1'b1;
                strb.lanes_on = 1'b1;
            end
            PH_RACCESS: begin
                strb.sel      = 1'b1;
                strb.lanes_on = 1'b1;
                strb.rd       = 1'b1;
            end
            default: strb = '0;
        endcase
    end
endmodule

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
    import sramc_pkg::*;
#(
    parameter int ADDR_W       = 20,
    parameter int DATA_W       = 16,
    parameter int CLK_PS       = 10000,
    parameter int T_POWERUP_PS = 1000000000,
    parameter int T_WC_PS      = 10000,
    parameter int T_PWE_PS     = 7000,
    parameter int T_SD_PS      = 5500,
    parameter int T_SA_PS      = 0,
    parameter int T_AA_PS      = 10000,
    parameter int T_DOE_PS     = 5000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [DATA_W/8-1:0]  req_bmask,
    output logic                 busy,
    output logic                 done,
    output logic [DATA_W-1:0]    rd_data,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic                 mem_sel_n,
    output logic                 mem_sel,
    output logic                 mem_wr_n,
    output logic                 mem_rd_n,
    output logic [DATA_W/8-1:0]  mem_lane_n,
    output logic [DATA_W-1:0]    mem_dq_o,
    output logic                 mem_dq_drive,
    input  logic [DATA_W-1:0]    mem_dq_i
);
    localparam int LANES    = DATA_W / 8;
    localparam int SETUP_C  = cycles_for(T_SA_PS, CLK_PS);
    localparam int PULSE_C  = cycles_for(max2(T_PWE_PS, T_SD_PS), CLK_PS);
    localparam int HOLD_C   = max2(1, cycles_for(T_WC_PS, CLK_PS) - SETUP_C - PULSE_C);
    localparam int ACCESS_C = cycles_for(max2(T_AA_PS, T_DOE_PS), CLK_PS);
    localparam int PWR_C    = cycles_for(T_POWERUP_PS, CLK_PS);

    logic              pwr_ok;
    logic              accept;
    logic              capture;
    phase_e            phase_q, phase_nx;
    strobe_t           strb;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  mask_q, mask_nx;
    logic [DATA_W-1:0] rd_masked;

    sramc_powerup #(.CYCLES(PWR_C)) u_pwr (
        .clk    (clk),
        .rst    (rst),
        .pwr_ok (pwr_ok)
    );

    assign busy   = !pwr_ok || (phase_q != PH_IDLE);
    assign accept = req_valid && !busy;

    sramc_seq #(
        .SETUP  (SETUP_C),
        .PULSE  (PULSE_C),
        .HOLD   (HOLD_C),
        .ACCESS (ACCESS_C)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (accept),
        .start_write (req_write),
        .phase_q     (phase_q),
        .phase_nx    (phase_nx),
        .capture     (capture),
        .done        (done)
    );

    sramc_decode u_dec (
        .phase (phase_nx),
        .strb  (strb)
    );

    assign mask_nx = accept ? req_bmask : mask_q;

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign rd_masked[l*8 +: 8] = mask_q[l] ? mem_dq_i[l*8 +: 8] : 8'h00;
        end
    endgenerate

    assign mem_addr = addr_q;
    assign mem_dq_o = wdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q       <= '0;
            wdata_q      <= '0;
            mask_q       <= '0;
            rd_data      <= '0;
            mem_sel_n    <= 1'b1;
            mem_sel      <= 1'b0;
            mem_wr_n     <= 1'b1;
            mem_rd_n     <= 1'b1;
            mem_lane_n   <= '1;
            mem_dq_drive <= 1'b0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                mask_q  <= req_bmask;
            end
            if (capture) begin
                rd_data <= rd_masked;
            end
            mem_sel_n    <= ~strb.sel;
            mem_sel      <= strb.sel;
            mem_wr_n     <= ~strb.wr;
            mem_rd_n     <= ~strb.rd;
            mem_lane_n   <= ~({LANES{strb.lanes_on}} & mask_nx);
            mem_dq_drive <= strb.drive;
        end
    end
endmodule

// File: rtl/sramc_ctrl_chk.sv
module sramc_ctrl_chk #(
    parameter int ADDR_W = 20,
    parameter int LANES  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              pwr_ok,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_sel_n,
    input logic              mem_sel,
    input logic              mem_wr_n,
    input logic              mem_rd_n,
    input logic [LANES-1:0]  mem_lane_n,
    input logic              mem_dq_drive
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (mem_sel_n && !mem_sel && mem_wr_n && mem_rd_n && (&mem_lane_n) && !mem_dq_drive && !done));

    assert_startup_lock_R2: assert property (@(posedge clk) disable iff (rst)
        !pwr_ok |-> (busy && mem_sel_n));

    assert_strobe_driven_R3: assert property (@(posedge clk) disable iff (rst)
        !mem_wr_n |-> (mem_dq_drive && !mem_sel_n && mem_rd_n));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_free_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_no_clash_R9: assert property (@(posedge clk) disable iff (rst)
        !(mem_dq_drive && !mem_rd_n));

    assert_turnaround_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_rd_n) |-> !$past(mem_dq_drive));

    assert_addr_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (!mem_sel_n && !$past(mem_sel_n)) |-> ($stable(mem_addr) && $stable(mem_lane_n)));

    assert_select_pair_R11: assert property (@(posedge clk) disable iff (rst)
        mem_sel_n == !mem_sel);
endmodule

bind sramc_ctrl sramc_ctrl_chk #(.ADDR_W(ADDR_W), .LANES(DATA_W/8)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pwr_ok       (pwr_ok),
    .busy         (busy),
    .done         (done),
    .mem_addr     (mem_addr),
    .mem_sel_n    (mem_sel_n),
    .mem_sel      (mem_sel),
    .mem_wr_n     (mem_wr_n),
    .mem_rd_n     (mem_rd_n),
    .mem_lane_n   (mem_lane_n),
    .mem_dq_drive (mem_dq_drive)
);

// File: tb/test_sramc_ctrl.sv
module test_sramc_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_PS     = 2500;
    localparam int PWR_PS     = 50000;
    // expected counts worked out from the requirements
    localparam int EXP_PWR    = 20;
    localparam int EXP_PULSE  = 3;
    localparam int EXP_ACCESS = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [19:0] req_addr  = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_bmask = '0;
    logic        busy, done;
    logic [15:0] rd_data;
    logic [19:0] mem_addr;
    logic        mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_dq_drive;
    logic [1:0]  mem_lane_n;
    logic [15:0] mem_dq_o, mem_dq_i;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sramc_ctrl #(.CLK_PS(CLK_PS), .T_POWERUP_PS(PWR_PS)) i_sramc_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_bmask(req_bmask),
        .busy(busy), .done(done), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_wr_n(mem_wr_n),
        .mem_rd_n(mem_rd_n), .mem_lane_n(mem_lane_n), .mem_dq_o(mem_dq_o),
        .mem_dq_drive(mem_dq_drive), .mem_dq_i(mem_dq_i)
    );

    // ---------------- RAM model and monitors ----------------
    logic [15:0] mem [64];
    logic        prev_wr_n = 1'b1, prev_rd_n = 1'b1, prev_sel_n = 1'b1, prev_done = 1'b0;
    logic [19:0] prev_addr = '0;
    logic [1:0]  prev_lane_n = 2'b11;
    int          wr_low_cnt = 0, last_pulse = 0, rd_low_cnt = 0;
    int          undriven = 0, last_gap = 0;
    logic [1:0]  last_wr_lanes_n = 2'b11;
    int          flag_addr = 0, flag_pair = 0, flag_done = 0, flag_clash = 0;
    logic [5:0]  idx;

    assign idx = mem_addr[5:0];
    assign mem_dq_i = (!mem_sel_n && !mem_rd_n && mem_wr_n && rd_low_cnt >= EXP_ACCESS - 1)
                      ? {mem_lane_n[1] ? 8'hA5 : mem[idx][15:8],
                         mem_lane_n[0] ? 8'hA5 : mem[idx][7:0]}
                      : 16'hDEAD;

    initial for (int i = 0; i < 64; i++) mem[i] = 16'h0000;

    always @(posedge clk) begin
        if (!rst) begin
            if (!mem_wr_n) wr_low_cnt <= wr_low_cnt + 1;
            if (mem_wr_n && !prev_wr_n) begin
                last_pulse      <= wr_low_cnt;
                wr_low_cnt      <= 0;
                last_wr_lanes_n <= mem_lane_n;
                if (!mem_sel_n && mem_sel) begin
                    if (!mem_lane_n[0]) mem[idx][7:0]  <= mem_dq_o[7:0];
                    if (!mem_lane_n[1]) mem[idx][15:8] <= mem_dq_o[15:8];
                end
            end
            rd_low_cnt <= !mem_rd_n ? rd_low_cnt + 1 : 0;
            undriven   <= mem_dq_drive ? 0 : undriven + 1;
            if (!mem_rd_n && prev_rd_n) last_gap <= undriven;
            if (!mem_sel_n && !prev_sel_n && (mem_addr != prev_addr || mem_lane_n != prev_lane_n))
                flag_addr <= flag_addr + 1;
            if (mem_sel_n == mem_sel) flag_pair <= flag_pair + 1;
            if (done && prev_done) flag_done <= flag_done + 1;
            if (mem_dq_drive && !mem_rd_n) flag_clash <= flag_clash + 1;
        end
        prev_wr_n   <= mem_wr_n;
        prev_rd_n   <= mem_rd_n;
        prev_sel_n  <= mem_sel_n;
        prev_addr   <= mem_addr;
        prev_lane_n <= mem_lane_n;
        prev_done   <= done;
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge where done is high
    task automatic issue(input bit wr, input logic [19:0] a, input logic [15:0] d, input logic [1:0] m);
        while (busy) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_bmask = m;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        repeat (3) @(negedge clk);
        check(mem_sel_n && !mem_sel && mem_wr_n && mem_rd_n && mem_lane_n == 2'b11
              && !mem_dq_drive && !done, "R1 idle in reset", {mem_sel_n, mem_sel, mem_wr_n, mem_rd_n}, 4'hB);
    endtask

    task automatic t_startup;
        int n = 0;
        bit sel_seen = 0;
        rst = 1'b0;
        while (n < 200) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (n == 3) begin
                req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h5; req_wdata = 16'hFFFF; req_bmask = 2'b11;
            end
            if (n == 5) req_valid = 1'b0;
            if (!mem_sel_n) sel_seen = 1;
            if (!busy) break;
        end
        check(n == EXP_PWR, "R2 start-up length", n, EXP_PWR);
        check(!sel_seen, "R2 deselected during start-up", sel_seen, 0);
        check(!done, "R1 no done after start-up", done, 0);
    endtask

    task automatic t_full_word;
        issue(1'b1, 20'h3, 16'h1234, 2'b11);
        check(last_pulse == EXP_PULSE, "R3 write strobe width", last_pulse, EXP_PULSE);
        check(mem[3] == 16'h1234, "R3 word stored", mem[3], 16'h1234);
        @(negedge clk);
        issue(1'b0, 20'h3, 16'h0, 2'b11);
        check(rd_data == 16'h1234, "R5 read after full access window", rd_data, 16'h1234);
        @(negedge clk);
        check(!done, "R6 done lasts one cycle", done, 0);
        issue(1'b0, 20'h5, 16'h0, 2'b11);
        check(rd_data == 16'h0000, "R2 start-up request dropped", rd_data, 0);
        @(negedge clk);
    endtask

    task automatic t_lanes;
        issue(1'b1, 20'h8, 16'hABCD, 2'b01);
        check(last_wr_lanes_n == 2'b10, "R4 low lane enable", last_wr_lanes_n, 2'b10);
        check(mem[8] == 16'h00CD, "R4 low lane only", mem[8], 16'h00CD);
        @(negedge clk);
        issue(1'b1, 20'h8, 16'h5677, 2'b10);
        check(last_wr_lanes_n == 2'b01, "R4 high lane enable", last_wr_lanes_n, 2'b01);
        check(mem[8] == 16'h56CD, "R4 high lane merge", mem[8], 16'h56CD);
        @(negedge clk);
        issue(1'b1, 20'h8, 16'hFFFF, 2'b00);
        check(mem[8] == 16'h56CD, "R4 empty mask no change", mem[8], 16'h56CD);
        @(negedge clk);
    endtask

    task automatic t_read_lanes;
        issue(1'b0, 20'h8, 16'h0, 2'b01);
        check(rd_data == 16'h00CD, "R7 high lane zeroed", rd_data, 16'h00CD);
        @(negedge clk);
        issue(1'b0, 20'h8, 16'h0, 2'b10);
        check(rd_data == 16'h5600, "R7 low lane zeroed", rd_data, 16'h5600);
        @(negedge clk);
        issue(1'b1, 20'h9, 16'h4444, 2'b11);
        check(rd_data == 16'h5600, "R6 read data held across write", rd_data, 16'h5600);
        @(negedge clk);
    endtask

    task automatic t_busy_ignore;
        bit b1, b2;
        while (busy) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h7; req_wdata = 16'h7777; req_bmask = 2'b11;
        @(negedge clk);
        req_addr = 20'hA; req_wdata = 16'hAAAA;
        b1 = busy;
        @(negedge clk);
        b2 = busy;
        req_valid = 1'b0;
        check(b1 && b2, "R8 busy during access", {b1, b2}, 2'b11);
        while (!done) @(negedge clk);
        check(mem[7] == 16'h7777, "R8 first request served", mem[7], 16'h7777);
        @(negedge clk);
        issue(1'b0, 20'hA, 16'h0, 2'b11);
        check(rd_data == 16'h0000, "R8 request while busy ignored", rd_data, 0);
        @(negedge clk);
    endtask

    task automatic t_turnaround;
        issue(1'b1, 20'hC, 16'h0C0C, 2'b11);
        issue(1'b0, 20'hC, 16'h0, 2'b11);
        check(last_gap == 2, "R9 undriven cycles before output enable", last_gap, 2);
        check(rd_data == 16'h0C0C, "R5 back-to-back read data", rd_data, 16'h0C0C);
        @(negedge clk);
    endtask

    task automatic t_monitors;
        check(flag_clash == 0, "R9 no drive while output enabled", flag_clash, 0);
        check(flag_addr == 0, "R10 address stable while selected", flag_addr, 0);
        check(flag_pair == 0, "R11 select pair complementary", flag_pair, 0);
        check(flag_done == 0, "R6 done never wider than one cycle", flag_done, 0);
    endtask

    bit finished = 0;

    initial begin
        @(negedge clk);
        t_reset();
        t_startup();
        t_full_word();
        t_lanes();
        t_read_lanes();
        t_busy_ignore();
        t_turnaround();
        t_monitors();
        finished = 1;
    end

    initial begin
        for (int i = 0; i < 20000 && !finished; i++) @(posedge clk);
        if (!finished) check(0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule